// File: doc/BRIEF.md
# Chipset Clock-Enable Strobe Generator

This block takes one fast base clock of about 28.375 MHz and produces every slower timing strobe that a vintage home-computer chipset needs. It does this without creating new clock domains. All downstream logic stays on the base clock and qualifies its registers with these strobes.

The outputs are:
- a 7 MHz rising-phase enable and a 7 MHz falling-phase enable;
- two 7 MHz square phases in quadrature;
- a colour-clock square wave at one eighth of the base rate;
- a one-cycle peripheral E-clock enable at one tenth of the 7 MHz rate.

The phase relations between the outputs are fixed. A 2-bit phase counter sets the 7 MHz position. A single toggle flop makes the colour clock. A small period counter, advanced once per 7 MHz period, places the E-clock pulse.

An active-low asynchronous reset loads the phase-0 values. While reset is low, the outputs show the first cycle's values. The cycle on which reset is released is base cycle 0, and counting starts from there. Every output comes straight from a flop, so consumers see clean, glitch-free strobes.

Top module: `chipset_strobe_gen`

## Requirements
- R1: While rst_n is low, en7_rise=1, en7_fall=0, ph7_lead=1, ph7_lag=0, cclk=0 and eclk_en=0. The cycle in which rst_n is first seen high is base cycle p=0.
- R2: en7_rise is high exactly on base cycles where p mod 4 equals 0, and is a single-cycle pulse.
- R3: en7_fall is high exactly on base cycles where p mod 4 equals 2, which is two base cycles after each en7_rise.
- R4: ph7_lead is high on base cycles where p mod 4 is 0 or 1, and low where it is 2 or 3.
- R5: ph7_lag is ph7_lead delayed by one base cycle (a quarter of the 7 MHz period): it is high where p mod 4 is 1 or 2.
- R6: cclk is low on base cycles where p mod 8 is 0 to 3 and high where it is 4 to 7. It changes only on cycles where en7_rise is high.
- R7: With divider D = ECLK_DIV (D at least 2, default 10), eclk_en is high only on base cycles where p mod (4*D) equals 4*D-4. It therefore always coincides with en7_rise.
- R8: Pulling rst_n low in the middle of a run returns all outputs to the R1 values at once. After release, counting restarts at p=0.
- R9: en7_rise and en7_fall are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock, nominally 28.37516 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| en7_rise | output | 1 | 7 MHz enable, one cycle every four |
| en7_fall | output | 1 | 7 MHz falling-half enable, two cycles after en7_rise |
| ph7_lead | output | 1 | 7 MHz square phase, leading |
| ph7_lag | output | 1 | 7 MHz square phase, one base cycle behind ph7_lead |
| cclk | output | 1 | Colour-clock square wave at one eighth of the base rate |
| eclk_en | output | 1 | E-clock enable, one cycle every 4*ECLK_DIV base cycles |

## Verification
The bench builds the block twice side by side: once with the default divider of 10 and once with a divider of 3. The default instance puts the 40-cycle E-clock period and its wrap under test across several periods. The divider-3 instance reaches the wrap of the period counter every 12 cycles and confirms that the pulse position follows the parameter. A reset asserted mid-period, at a point where the colour clock is high and the period counter is non-zero, shows that every counter goes back to phase 0 together.

// File: rtl/chipset_strobe_gen.sv
module chipset_strobe_gen #(
  parameter int ECLK_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic en7_rise,
  output logic en7_fall,
  output logic ph7_lead,
  output logic ph7_lag,
  output logic cclk,
  output logic eclk_en
);

  localparam int EW = (ECLK_DIV > 2) ? $clog2(ECLK_DIV) : 1;
  localparam logic [EW-1:0] E_LAST = EW'(ECLK_DIV - 1);
  localparam logic [EW-1:0] E_PRE  = EW'(ECLK_DIV - 2);

  logic [1:0]    q;
  logic [EW-1:0] per;
  logic          wrap;

  assign wrap = (q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= 2'd0;
      per      <= '0;
      en7_rise <= 1'b1;
      en7_fall <= 1'b0;
      ph7_lead <= 1'b1;
      ph7_lag  <= 1'b0;
      cclk     <= 1'b0;
      eclk_en  <= 1'b0;
    end else begin
      q        <= q + 2'd1;
      en7_rise <= wrap;
      en7_fall <= (q == 2'd1);
      ph7_lead <= wrap || (q == 2'd0);
      ph7_lag  <= (q == 2'd0) || (q == 2'd1);
      cclk     <= cclk ^ wrap;
      eclk_en  <= wrap && (per == E_PRE);
      if (wrap)
        per <= (per == E_LAST) ? '0 : per + 1'b1;
    end
  end

  a_r2_rise_period: assert property (@(posedge clk) disable iff (!rst_n)
    en7_rise |-> ##4 en7_rise);
  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    en7_rise |=> !en7_rise);
  a_r3_fall_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    en7_rise |-> ##2 en7_fall);
  a_r5_lag_follows_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph7_lead) |=> ph7_lag);
  a_r5_lag_follows_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph7_lead) |=> !ph7_lag);
  a_r6_cclk_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cclk) |-> en7_rise);
  a_r7_eclk_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    eclk_en |-> en7_rise);
  a_r9_rise_fall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en7_rise, en7_fall}));

endmodule

// File: tb/chipset_strobe_gen_bench.sv
module chipset_strobe_gen_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  logic a_rise, a_fall, a_lead, a_lag, a_cclk, a_ecl;
  logic b_rise, b_fall, b_lead, b_lag, b_cclk, b_ecl;

  always #2 clk = ~clk;

  chipset_strobe_gen u_chipset_strobe_gen (
    .clk(clk), .rst_n(rst_n),
    .en7_rise(a_rise), .en7_fall(a_fall), .ph7_lead(a_lead),
    .ph7_lag(a_lag), .cclk(a_cclk), .eclk_en(a_ecl)
  );

  chipset_strobe_gen #(.ECLK_DIV(3)) u_chipset_strobe_gen_d3 (
    .clk(clk), .rst_n(rst_n),
    .en7_rise(b_rise), .en7_fall(b_fall), .ph7_lead(b_lead),
    .ph7_lag(b_lag), .cclk(b_cclk), .eclk_en(b_ecl)
  );

  task automatic chk(input string tag, input int p, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at p=%0d: actual=%b expected=%b", tag, p, act, exp);
    end
  endtask

  task automatic check_phase(input int p);
    int m4 = p % 4;
    int m8 = p % 8;
    chk("R2 en7_rise", p, a_rise, m4 == 0);
    chk("R3 en7_fall", p, a_fall, m4 == 2);
    chk("R4 ph7_lead", p, a_lead, m4 <= 1);
    chk("R5 ph7_lag",  p, a_lag,  m4 == 1 || m4 == 2);
    chk("R6 cclk",     p, a_cclk, m8 >= 4);
    chk("R7 eclk_en div10", p, a_ecl, (p % 40) == 36);
    chk("R9 rise/fall excl", p, a_rise & a_fall, 1'b0);
    chk("R2 en7_rise d3", p, b_rise, m4 == 0);
    chk("R6 cclk d3",     p, b_cclk, m8 >= 4);
    chk("R7 eclk_en div3", p, b_ecl, (p % 12) == 8);
  endtask

  task automatic check_reset_values(input string tag);
    chk({tag, " en7_rise"}, -1, a_rise, 1'b1);
    chk({tag, " en7_fall"}, -1, a_fall, 1'b0);
    chk({tag, " ph7_lead"}, -1, a_lead, 1'b1);
    chk({tag, " ph7_lag"},  -1, a_lag,  1'b0);
    chk({tag, " cclk"},     -1, a_cclk, 1'b0);
    chk({tag, " eclk_en"},  -1, a_ecl,  1'b0);
    chk({tag, " eclk_en d3"}, -1, b_ecl, 1'b0);
    chk({tag, " cclk d3"},    -1, b_cclk, 1'b0);
  endtask

  task automatic run_from_release(input int cycles);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_phase(0);
    for (int p = 1; p < cycles; p++) begin
      @(negedge clk);
      #1;
      check_phase(p);
    end
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    check_reset_values("R1 held");
  endtask

  task automatic t_long_run;
    run_from_release(200);
  endtask

  task automatic t_midrun_reset;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_values("R8 async");
    repeat (3) @(negedge clk);
    #1;
    check_reset_values("R8 held");
    run_from_release(90);
  endtask

  task automatic t_partial_then_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    run_from_release(23);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_values("R8 mid-period");
    run_from_release(50);
  endtask

  initial begin
    t_reset_state();
    t_long_run();
    t_midrun_reset();
    t_partial_then_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule